// File: doc/BRIEF.md
# ATA PIO Cycle Timing Engine

This block carries out one programmed-I/O register access on a parallel ATA bus for each host request. It places the register address on the three device address lines, asserts one of the two active-low chip selects, and pulses the active-low read or write strobe. For writes it drives the 16-bit data bus, and for reads it captures the data bus. It then returns a one-cycle acknowledge to the host.

Every access runs through four counted phases: address setup, strobe, hold and end-of-cycle recovery. Each phase takes its length from one of three timing words. A compatible word serves all register accesses. Two fast words, one per device, serve data-port accesses when fast timing is enabled for the device currently selected. Each timing word has its own enable for stretching the strobe with the device ready line. The block also drives the bus reset line from a control bit and forwards the device interrupt.

Top module: `ata_pio_engine`

## Requirements
- R1: A timing word packs T1 in bits [7:0], T2 in [15:8], T4 in [23:16] and Teoc in [31:24]. After a request is accepted, the chip select and address are valid with no strobe for T1 cycles. The strobe is then low for T2 cycles. Chip select and address stay valid with the strobe released for T4 cycles.
- R2: A phase count of 0 lasts exactly one cycle.
- R3: The acknowledge cycle is the first of max(Teoc,1) recovery cycles. With the request held, chip select is inactive for exactly max(Teoc,1)+1 cycles, counted from the acknowledge cycle, before the next access starts.
- R4: Address bit 3 = 0 selects cs0_n and address bit 3 = 1 selects cs1_n. da carries address bits 2:0. The two chip selects are never low together, and both are high outside setup, strobe and hold.
- R5: A write (we=1) pulses diow_n. Throughout the access dd_oe is high and dd_out equals the write data. A read (we=0) pulses dior_n with dd_oe low.
- R6: For a read, rdata takes the value of dd_in at the edge where the strobe is released, and holds it until the next read.
- R7: ack is high for exactly one cycle, the cycle after the last hold cycle.
- R8: Address 0 is the data port. A write to address 6 records wdata bit 4 as the selected device, which is 0 after reset. A data-port access uses the dev0 word when device 0 is selected and fast_dev0=1. It uses the dev1 word when device 1 is selected and fast_dev1=1. Every other access uses the compatible word.
- R9: When the chosen word's ready-enable is 1 and iordy is low, the strobe is held past T2 until iordy, seen through a two-flop synchronizer, is high. With the enable at 0, iordy has no effect.
- R10: While ctl_enable is 0, no request is accepted: no chip select, no strobe and no ack.
- R11: ata_reset_n is the inverse of ctl_bus_reset.
- R12: irq follows intrq one clock later.
- R13: After rst_n or sync_clr, the bus is idle: both chip selects and both strobes are high, dd_oe is 0 and ack is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sync_clr | input | 1 | Synchronous clear, active high |
| ctl_enable | input | 1 | Allows accesses to start |
| ctl_bus_reset | input | 1 | Drives the bus reset line when 1 |
| ctl_fast_dev0 | input | 1 | Fast data-port timing for device 0 |
| ctl_fast_dev1 | input | 1 | Fast data-port timing for device 1 |
| cmp_timing | input | 32 | Compatible timing word |
| cmp_iordy_en | input | 1 | Ready stretch enable, compatible word |
| dev0_timing | input | 32 | Fast timing word, device 0 |
| dev0_iordy_en | input | 1 | Ready stretch enable, device 0 |
| dev1_timing | input | 32 | Fast timing word, device 1 |
| dev1_iordy_en | input | 1 | Ready stretch enable, device 1 |
| req | input | 1 | Access request, held until ack |
| addr | input | 4 | Register address |
| we | input | 1 | 1 = write, 0 = read |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Captured read data |
| ack | output | 1 | Access complete, one cycle |
| ata_reset_n | output | 1 | Bus reset, active low |
| dd_in | input | 16 | Data bus input |
| dd_out | output | 16 | Data bus output |
| dd_oe | output | 1 | Data bus output enable |
| da | output | 3 | Device address |
| cs0_n | output | 1 | Command block select, active low |
| cs1_n | output | 1 | Control block select, active low |
| dior_n | output | 1 | Read strobe, active low |
| diow_n | output | 1 | Write strobe, active low |
| iordy | input | 1 | Device ready |
| intrq | input | 1 | Device interrupt |
| irq | output | 1 | Interrupt request to host |

## Verification
The bench keeps the default data width of 16 and the 8-bit counters. It programs the timing words with small values, between 0 and 7 cycles, instead of the slow reset-mode counts. Each phase can then be counted exactly at the pins within a few dozen cycles. With these values the zero-count rule, the choice between the fast and compatible words after a device-select write, and a strobe stretched far past T2 by the ready line all fit in a short run.

// File: rtl/ata_pio_pkg.sv
// Shared definitions for the ATA PIO timing engine.
// Assumes 8-bit phase counts packed four to a 32-bit timing word.
package ata_pio_pkg;
    localparam int TW = 8;
    localparam int AW = 4;

    // Packed so that t1 sits in the low byte and teoc in the high byte.
    typedef struct packed {
        logic [TW-1:0] teoc;
        logic [TW-1:0] t4;
        logic [TW-1:0] t2;
        logic [TW-1:0] t1;
    } tset_t;

    typedef enum logic [2:0] {
        PH_IDLE, PH_SETUP, PH_STROBE, PH_HOLD, PH_RECOV
    } phase_t;

    localparam logic [AW-1:0] ADDR_DATA = 4'd0;
    localparam logic [AW-1:0] ADDR_DEVH = 4'd6;
    localparam int DEV_BIT = 4;

    // Counter load value: a programmed count of 0 still spans one cycle.
    function automatic logic [TW-1:0] load_count(input logic [TW-1:0] t);
        return (t == '0) ? '0 : t - 1'b1;
    endfunction
endpackage

// File: rtl/ata_pio_sync.sv
// Multi-flop synchronizer for a single asynchronous level.
// Assumes STAGES >= 2; output resets to RST_VAL.
module ata_pio_sync #(
    parameter int STAGES = 2,
    parameter bit RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the input through the flop chain.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/ata_pio_tsel.sv
// Timing word selection and device-select tracking.
// Assumes `start` is high for one cycle when an access is accepted.
module ata_pio_tsel
    import ata_pio_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sync_clr,
    input  logic          start,
    input  logic [AW-1:0] addr,
    input  logic          we,
    input  logic          wr_dev_bit,
    input  logic          fast_dev0,
    input  logic          fast_dev1,
    input  tset_t         cmp_set,
    input  logic          cmp_ien,
    input  tset_t         dev0_set,
    input  logic          dev0_ien,
    input  tset_t         dev1_set,
    input  logic          dev1_ien,
    output tset_t         sel_set,
    output logic          sel_ien
);
    logic dev_q;

    // Record the device-select bit on writes to the drive/head register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                  dev_q <= 1'b0;
        else if (sync_clr)                           dev_q <= 1'b0;
        else if (start && we && addr == ADDR_DEVH)   dev_q <= wr_dev_bit;
    end

    // Pick the fast word only for data-port accesses to a fast device.
    always_comb begin
        sel_set = cmp_set;
        sel_ien = cmp_ien;
        if (addr == ADDR_DATA) begin
            if (!dev_q && fast_dev0) begin
                sel_set = dev0_set;
                sel_ien = dev0_ien;
            end else if (dev_q && fast_dev1) begin
                sel_set = dev1_set;
                sel_ien = dev1_ien;
            end
        end
    end
endmodule

// File: rtl/ata_pio_seq.sv
// Four-phase access sequencer: setup, strobe, hold, recovery.
// Assumes the timing word and request fields are valid when start is high.
module ata_pio_seq
    import ata_pio_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sync_clr,
    input  logic          start,
    input  logic [AW-1:0] addr,
    input  logic          we,
    input  logic [DW-1:0] wdata,
    input  tset_t         tset,
    input  logic          ien,
    input  logic          rdy,
    input  logic [DW-1:0] dd_in,
    output logic          idle,
    output logic [DW-1:0] rdata,
    output logic          ack,
    output logic [DW-1:0] dd_out,
    output logic          dd_oe,
    output logic [2:0]    da,
    output logic          cs0_n,
    output logic          cs1_n,
    output logic          dior_n,
    output logic          diow_n
);
    phase_t        ph_q;
    logic [TW-1:0] cnt_q;
    logic [AW-1:0] addr_q;
    logic          we_q;
    logic [DW-1:0] wd_q;
    tset_t         set_q;
    logic          ien_q;
    logic [DW-1:0] rd_q;
    logic          ack_q;
    logic          busy;
    logic          cnt_done;
    logic          stall;

    assign cnt_done = (cnt_q == '0);
    assign stall    = ien_q && !rdy;

    // Phase state machine with per-phase down counter.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q <= PH_IDLE; cnt_q <= '0; addr_q <= '0; we_q <= 1'b0;
            wd_q <= '0; set_q <= '0; ien_q <= 1'b0; rd_q <= '0; ack_q <= 1'b0;
        end else if (sync_clr) begin
            ph_q <= PH_IDLE; cnt_q <= '0; addr_q <= '0; we_q <= 1'b0;
            wd_q <= '0; set_q <= '0; ien_q <= 1'b0; rd_q <= '0; ack_q <= 1'b0;
        end else begin
            ack_q <= 1'b0;
            unique case (ph_q)
                PH_IDLE: if (start) begin
                    ph_q   <= PH_SETUP;
                    cnt_q  <= load_count(tset.t1);
                    addr_q <= addr;
                    we_q   <= we;
                    wd_q   <= wdata;
                    set_q  <= tset;
                    ien_q  <= ien;
                end
                PH_SETUP: if (cnt_done) begin
                    ph_q  <= PH_STROBE;
                    cnt_q <= load_count(set_q.t2);
                end else cnt_q <= cnt_q - 1'b1;
                PH_STROBE: if (!cnt_done) cnt_q <= cnt_q - 1'b1;
                else if (!stall) begin
                    ph_q  <= PH_HOLD;
                    cnt_q <= load_count(set_q.t4);
                    if (!we_q) rd_q <= dd_in;
                end
                PH_HOLD: if (cnt_done) begin
                    ph_q  <= PH_RECOV;
                    cnt_q <= load_count(set_q.teoc);
                    ack_q <= 1'b1;
                end else cnt_q <= cnt_q - 1'b1;
                PH_RECOV: if (cnt_done) ph_q <= PH_IDLE;
                else cnt_q <= cnt_q - 1'b1;
                default: ph_q <= PH_IDLE;
            endcase
        end
    end

    // Bus pins decoded from the registered phase.
    always_comb begin
        busy   = (ph_q == PH_SETUP) || (ph_q == PH_STROBE) || (ph_q == PH_HOLD);
        idle   = (ph_q == PH_IDLE);
        cs0_n  = !(busy && !addr_q[AW-1]);
        cs1_n  = !(busy && addr_q[AW-1]);
        da     = addr_q[2:0];
        dior_n = !(ph_q == PH_STROBE && !we_q);
        diow_n = !(ph_q == PH_STROBE && we_q);
        dd_oe  = busy && we_q;
        dd_out = wd_q;
        rdata  = rd_q;
        ack    = ack_q;
    end
endmodule

// File: rtl/ata_pio_engine.sv
// Top of the ATA PIO cycle timing engine.
// Assumes the host holds req and its fields stable until ack.
module ata_pio_engine
    import ata_pio_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int SYNC_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_clr,
    input  logic              ctl_enable,
    input  logic              ctl_bus_reset,
    input  logic              ctl_fast_dev0,
    input  logic              ctl_fast_dev1,
    input  logic [4*TW-1:0]   cmp_timing,
    input  logic              cmp_iordy_en,
    input  logic [4*TW-1:0]   dev0_timing,
    input  logic              dev0_iordy_en,
    input  logic [4*TW-1:0]   dev1_timing,
    input  logic              dev1_iordy_en,
    input  logic              req,
    input  logic [AW-1:0]     addr,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              ack,
    output logic              ata_reset_n,
    input  logic [DATA_W-1:0] dd_in,
    output logic [DATA_W-1:0] dd_out,
    output logic              dd_oe,
    output logic [2:0]        da,
    output logic              cs0_n,
    output logic              cs1_n,
    output logic              dior_n,
    output logic              diow_n,
    input  logic              iordy,
    input  logic              intrq,
    output logic              irq
);
    logic  idle;
    logic  start;
    logic  rdy_s;
    tset_t sel_set;
    logic  sel_ien;
    logic  irq_q;

    assign start       = req && ctl_enable && idle;
    assign ata_reset_n = !ctl_bus_reset;
    assign irq         = irq_q;

    // Register the device interrupt toward the host.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        irq_q <= 1'b0;
        else if (sync_clr) irq_q <= 1'b0;
        else               irq_q <= intrq;
    end

    ata_pio_sync #(.STAGES(SYNC_DEPTH), .RST_VAL(1'b1)) i_rdy_sync (
        .clk(clk), .rst_n(rst_n), .d(iordy), .q(rdy_s)
    );

    ata_pio_tsel i_tsel (
        .clk(clk), .rst_n(rst_n), .sync_clr(sync_clr), .start(start),
        .addr(addr), .we(we), .wr_dev_bit(wdata[DEV_BIT]),
        .fast_dev0(ctl_fast_dev0), .fast_dev1(ctl_fast_dev1),
        .cmp_set(tset_t'(cmp_timing)),   .cmp_ien(cmp_iordy_en),
        .dev0_set(tset_t'(dev0_timing)), .dev0_ien(dev0_iordy_en),
        .dev1_set(tset_t'(dev1_timing)), .dev1_ien(dev1_iordy_en),
        .sel_set(sel_set), .sel_ien(sel_ien)
    );

    ata_pio_seq #(.DW(DATA_W)) i_seq (
        .clk(clk), .rst_n(rst_n), .sync_clr(sync_clr), .start(start),
        .addr(addr), .we(we), .wdata(wdata), .tset(sel_set), .ien(sel_ien),
        .rdy(rdy_s), .dd_in(dd_in), .idle(idle), .rdata(rdata), .ack(ack),
        .dd_out(dd_out), .dd_oe(dd_oe), .da(da), .cs0_n(cs0_n), .cs1_n(cs1_n),
        .dior_n(dior_n), .diow_n(diow_n)
    );
endmodule

// File: rtl/ata_pio_checker.sv
// Protocol checker for the ATA PIO engine pins, bound to the top module.
// Assumes rst_n and sync_clr both return the bus to idle.
module ata_pio_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       sync_clr,
    input logic       ack,
    input logic       dior_n,
    input logic       diow_n,
    input logic       cs0_n,
    input logic       cs1_n,
    input logic       dd_oe,
    input logic [2:0] da,
    input logic       ctl_enable,
    input logic       req
);
    AST_CS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n || sync_clr)
        !(!cs0_n && !cs1_n)); // R4
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n || sync_clr)
        !(!dior_n && !diow_n)); // R5
    AST_STROBE_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n || sync_clr)
        (!dior_n || !diow_n) |-> (!cs0_n || !cs1_n)); // R4
    AST_OE_NOT_ON_READ: assert property (@(posedge clk) disable iff (!rst_n || sync_clr)
        dd_oe |-> dior_n); // R5
    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n || sync_clr)
        ack |=> !ack); // R7
    AST_ACK_AFTER_CS: assert property (@(posedge clk) disable iff (!rst_n || sync_clr)
        ack |-> (cs0_n && cs1_n && dior_n && diow_n)); // R7
    AST_DA_STABLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n || sync_clr)
        (!dior_n || !diow_n) && $past(!dior_n || !diow_n) |-> $stable(da)); // R4
    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n || sync_clr)
        (cs0_n && cs1_n && !ctl_enable) |=> (cs0_n && cs1_n)); // R10
    AST_NO_START_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n || sync_clr)
        (cs0_n && cs1_n && !req && !ack) |=> !ack); // R7
endmodule

bind ata_pio_engine ata_pio_checker i_ata_pio_checker (
    .clk(clk), .rst_n(rst_n), .sync_clr(sync_clr), .ack(ack),
    .dior_n(dior_n), .diow_n(diow_n), .cs0_n(cs0_n), .cs1_n(cs1_n),
    .dd_oe(dd_oe), .da(da), .ctl_enable(ctl_enable), .req(req)
);

// File: tb/test_ata_pio_engine.sv
module test_ata_pio_engine;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sync_clr = 1'b0;
    logic        ctl_enable = 1'b1;
    logic        ctl_bus_reset = 1'b0;
    logic        ctl_fast_dev0 = 1'b0;
    logic        ctl_fast_dev1 = 1'b0;
    logic [31:0] cmp_timing  = 32'h04_02_05_03;
    logic        cmp_iordy_en = 1'b0;
    logic [31:0] dev0_timing = 32'h02_01_02_01;
    logic        dev0_iordy_en = 1'b0;
    logic [31:0] dev1_timing = 32'h01_03_07_02;
    logic        dev1_iordy_en = 1'b0;
    logic        req = 1'b0;
    logic [3:0]  addr = '0;
    logic        we = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        ack;
    logic        ata_reset_n;
    logic [15:0] dd_in = 16'h0;
    logic [15:0] dd_out;
    logic        dd_oe;
    logic [2:0]  da;
    logic        cs0_n, cs1_n, dior_n, diow_n;
    logic        iordy = 1'b1;
    logic        intrq = 1'b0;
    logic        irq;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ata_pio_engine i_ata_pio_engine (
        .clk(clk), .rst_n(rst_n), .sync_clr(sync_clr), .ctl_enable(ctl_enable),
        .ctl_bus_reset(ctl_bus_reset), .ctl_fast_dev0(ctl_fast_dev0),
        .ctl_fast_dev1(ctl_fast_dev1), .cmp_timing(cmp_timing),
        .cmp_iordy_en(cmp_iordy_en), .dev0_timing(dev0_timing),
        .dev0_iordy_en(dev0_iordy_en), .dev1_timing(dev1_timing),
        .dev1_iordy_en(dev1_iordy_en), .req(req), .addr(addr), .we(we),
        .wdata(wdata), .rdata(rdata), .ack(ack), .ata_reset_n(ata_reset_n),
        .dd_in(dd_in), .dd_out(dd_out), .dd_oe(dd_oe), .da(da), .cs0_n(cs0_n),
        .cs1_n(cs1_n), .dior_n(dior_n), .diow_n(diow_n), .iordy(iordy),
        .intrq(intrq), .irq(irq)
    );

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    function automatic int eff(input logic [7:0] t);
        return (t == 0) ? 1 : int'(t);
    endfunction

    // One access; counts phase lengths at the pins and checks bus values.
    task automatic access(input logic [3:0] a, input bit w, input logic [15:0] d,
                          output int n1, output int n2, output int n4, output bit bus_ok);
        int phase = 0;
        int guard = 0;
        bit cs_act, strobe;
        n1 = 0; n2 = 0; n4 = 0; bus_ok = 1'b1;
        @(negedge clk);
        req = 1'b1; addr = a; we = w; wdata = d;
        forever begin
            @(negedge clk);
            guard++;
            if (ack || guard > 500) break;
            cs_act = !cs0_n || !cs1_n;
            strobe = !dior_n || !diow_n;
            if (cs_act) begin
                if (da != a[2:0] || cs0_n != a[3] || cs1_n != !a[3] || dd_oe != w) bus_ok = 1'b0;
                if (w && dd_out != d) bus_ok = 1'b0;
                if (strobe && (dior_n != w || diow_n != !w)) bus_ok = 1'b0;
            end else if (strobe || phase != 0 || n1 != 0) bus_ok = 1'b0;
            if (strobe) begin n2++; phase = 1; end
            else if (cs_act) begin if (phase == 0) n1++; else n4++; end
        end
        req = 1'b0;
        @(negedge clk);
        chk(!ack, "R7 ack single cycle", ack, 0);
        repeat (10) @(negedge clk);
    endtask

    task automatic t_reset;
        chk(cs0_n && cs1_n, "R13 chip selects idle after reset", {cs0_n, cs1_n}, 3);
        chk(dior_n && diow_n, "R13 strobes idle after reset", {dior_n, diow_n}, 3);
        chk(!dd_oe && !ack, "R13 oe and ack low after reset", {dd_oe, ack}, 0);
    endtask

    task automatic t_compat_read;
        int n1, n2, n4; bit ok;
        dd_in = 16'hA55A;
        access(4'h7, 1'b0, 16'h0, n1, n2, n4, ok);
        chk(n1 == 3, "R1 setup length", n1, 3);
        chk(n2 == 5, "R1 strobe length", n2, 5);
        chk(n4 == 2, "R1 hold length", n4, 2);
        chk(ok, "R4 R5 read bus pins", ok, 1);
        chk(rdata == 16'hA55A, "R6 read data captured", rdata, 16'hA55A);
    endtask

    task automatic t_ctrl_write;
        int n1, n2, n4; bit ok;
        dd_in = 16'h1111;
        access(4'hE, 1'b1, 16'hBEEF, n1, n2, n4, ok);
        chk(ok, "R4 R5 write to control block", ok, 1);
        chk(n2 == 5, "R5 write strobe length", n2, 5);
        chk(rdata == 16'hA55A, "R6 rdata kept across write", rdata, 16'hA55A);
    endtask

    task automatic t_zero_counts;
        int n1, n2, n4; bit ok;
        cmp_timing = 32'h0;
        access(4'h1, 1'b0, 16'h0, n1, n2, n4, ok);
        chk(n1 == 1 && n2 == 1 && n4 == 1, "R2 zero count phases", n1*100 + n2*10 + n4, 111);
        cmp_timing = 32'h04_02_05_03;
    endtask

    task automatic t_recovery;
        int g = 0; int guard = 0;
        @(negedge clk);
        req = 1'b1; addr = 4'h2; we = 1'b0;
        while (!ack && guard < 500) begin @(negedge clk); guard++; end
        while ((cs0_n && cs1_n) && guard < 500) begin g++; @(negedge clk); guard++; end
        chk(g == eff(8'd4) + 1, "R3 recovery gap", g, eff(8'd4) + 1);
        req = 1'b0;
        while (!ack && guard < 500) begin @(negedge clk); guard++; end
        repeat (10) @(negedge clk);
    endtask

    task automatic t_timing_select;
        int n1, n2, n4; bit ok;
        ctl_fast_dev0 = 1'b1;
        access(4'h0, 1'b0, 16'h0, n1, n2, n4, ok);
        chk(n1 == 1 && n2 == 2 && n4 == 1, "R8 dev0 fast word", n1*100 + n2*10 + n4, 121);
        access(4'h3, 1'b0, 16'h0, n1, n2, n4, ok);
        chk(n2 == 5, "R8 non-data port uses compatible word", n2, 5);
        access(4'h6, 1'b1, 16'h0010, n1, n2, n4, ok);
        ctl_fast_dev1 = 1'b1;
        access(4'h0, 1'b0, 16'h0, n1, n2, n4, ok);
        chk(n1 == 2 && n2 == 7 && n4 == 3, "R8 dev1 fast word", n1*100 + n2*10 + n4, 273);
        ctl_fast_dev1 = 1'b0;
        access(4'h0, 1'b0, 16'h0, n1, n2, n4, ok);
        chk(n2 == 5, "R8 dev1 not fast uses compatible word", n2, 5);
        access(4'h6, 1'b1, 16'h0000, n1, n2, n4, ok);
        ctl_fast_dev0 = 1'b0;
    endtask

    task automatic t_iordy;
        int n2 = 0; int guard = 0;
        int m1, m2, m4; bit ok;
        iordy = 1'b0;
        access(4'h2, 1'b0, 16'h0, m1, m2, m4, ok);
        chk(m2 == 5, "R9 iordy ignored when disabled", m2, 5);
        cmp_iordy_en = 1'b1;
        repeat (4) @(negedge clk);
        req = 1'b1; addr = 4'h2; we = 1'b0;
        while (!ack && guard < 500) begin
            @(negedge clk); guard++;
            if (!dior_n) begin n2++; if (n2 == 20) iordy = 1'b1; end
        end
        req = 1'b0;
        chk(n2 >= 21 && n2 <= 23, "R9 strobe stretched by iordy", n2, 22);
        cmp_iordy_en = 1'b0;
        repeat (10) @(negedge clk);
    endtask

    task automatic t_disabled;
        bit quiet = 1'b1;
        ctl_enable = 1'b0;
        @(negedge clk);
        req = 1'b1; addr = 4'h1; we = 1'b0;
        repeat (15) begin @(negedge clk); if (!cs0_n || !cs1_n || ack) quiet = 1'b0; end
        req = 1'b0;
        chk(quiet, "R10 request ignored while disabled", quiet, 1);
        ctl_enable = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset_irq;
        ctl_bus_reset = 1'b1; @(negedge clk);
        chk(ata_reset_n == 1'b0, "R11 bus reset asserted", ata_reset_n, 0);
        ctl_bus_reset = 1'b0; @(negedge clk);
        chk(ata_reset_n == 1'b1, "R11 bus reset released", ata_reset_n, 1);
        intrq = 1'b1;
        #1 chk(irq == 1'b0, "R12 irq not before clock", irq, 0);
        @(negedge clk);
        chk(irq == 1'b1, "R12 irq follows intrq", irq, 1);
        intrq = 1'b0; @(negedge clk);
        chk(irq == 1'b0, "R12 irq clears", irq, 0);
    endtask

    task automatic t_sync_clear;
        bit quiet = 1'b1;
        @(negedge clk);
        req = 1'b1; addr = 4'h1; we = 1'b1; wdata = 16'h1234;
        repeat (4) @(negedge clk);
        req = 1'b0; sync_clr = 1'b1;
        @(negedge clk);
        sync_clr = 1'b0;
        repeat (10) begin
            if (!cs0_n || !cs1_n || !diow_n || dd_oe || ack) quiet = 1'b0;
            @(negedge clk);
        end
        chk(quiet, "R13 sync clear returns bus to idle", quiet, 1);
    endtask

    initial begin
        int cyc = 0;
        while (cyc < 100000) begin @(posedge clk); cyc++; end
        chk(1'b0, "watchdog expired", cyc, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_compat_read();
        t_ctrl_write();
        t_zero_counts();
        t_recovery();
        t_timing_select();
        t_iordy();
        t_disabled();
        t_reset_irq();
        t_sync_clear();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule